// File: doc/BRIEF.md
# Reservation monitor for load-linked / store-conditional pairs

This block lets a single processor build atomic read-modify-write sequences on memory that other agents also write. A load-linked request places a reservation on the word that holds the addressed byte. A later store-conditional may write memory only while that reservation is still in force.

The block also watches a stream of write notices from other agents. Any notice that lands on the reserved word, an exception or context switch, or any store-conditional ends the reservation. For each store-conditional the block drives a store-enable with the address and data to memory. It also returns 1 (success) or 0 (failure) for the destination register, and software retries the pair whenever it reads 0.

Only one reservation is held at a time. The memory array and the coherence protocol sit outside the block. Word addresses drop the low `OFS_W` address bits (2 by default).

Top module: `excl_reserve_unit`

## Requirements
- R1: A load-linked (`ll_req`) with no `flush` in the same cycle makes the word of `ll_addr` the reserved word. A store-conditional to that word in a later cycle, with nothing in between that clears it, succeeds.
- R2: A successful store-conditional drives `mem_we`=1 in the cycle after the request. In that cycle `mem_waddr` equals `sc_addr` and `mem_wdata` equals `sc_data`, and `sc_done`=1 with `sc_status`=1.
- R3: A store-conditional while no reservation is held fails. It leaves `mem_we`=0 and returns `sc_done`=1 with `sc_status`=0 in the next cycle.
- R4: A store-conditional whose word differs from the reserved word fails. Address bits below `OFS_W` take no part in the compare, so a different byte in the reserved word still succeeds.
- R5: A write notice (`ext_wr`) whose `ext_addr` falls in the reserved word, at any byte, clears the reservation. A notice to any other word leaves it intact.
- R6: Every store-conditional clears the reservation, whether it succeeds or fails. A second one without a new load-linked fails.
- R7: A new load-linked replaces any older reservation. A store-conditional to the older word then fails.
- R8: `flush` clears the reservation, fails a store-conditional in the same cycle, and wins over a load-linked in the same cycle.
- R9: Same-cycle ordering is fixed as follows. A write notice hitting the reserved word fails a store-conditional in that cycle. A store-conditional issued with a load-linked is judged on the old reservation, and the new reservation is kept afterwards. A write notice in the same cycle as a load-linked to the same word is ordered before the load, so the reservation holds.
- R10: While `rst_n` is low at a clock edge, `mem_we`, `sc_done`, `sc_status`, `mem_waddr` and `mem_wdata` go to 0 and the reservation is dropped.
- R11: `sc_done` is 1 in exactly the cycle after each store-conditional and 0 otherwise. `sc_status` is always 0 or 1, and `mem_we` is never 1 without `sc_done`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ll_req | input | 1 | Load-linked issued this cycle |
| ll_addr | input | ADDR_W | Byte address of the load-linked |
| sc_req | input | 1 | Store-conditional issued this cycle |
| sc_addr | input | ADDR_W | Byte address of the store-conditional |
| sc_data | input | DATA_W | Register value to store |
| ext_wr | input | 1 | Write notice from another agent |
| ext_addr | input | ADDR_W | Byte address of that write |
| flush | input | 1 | Exception or context switch |
| mem_we | output | 1 | Store-enable to memory |
| mem_waddr | output | ADDR_W | Store address |
| mem_wdata | output | DATA_W | Store data |
| sc_done | output | 1 | Result for the destination register is valid |
| sc_status | output | DATA_W | 1 on success, 0 on failure |

## Verification
The bench targets the same-cycle collisions. These are a write notice beside a store-conditional, a load-linked beside a store-conditional, a flush beside a load-linked, and a write notice beside a load-linked. An error in any of these orderings would let a store through after a conflicting write, or lose a reservation the software holds.

It also uses addresses that differ only in the low byte bits. A design that compared the full address would fail a valid store, or miss a conflicting write to another byte of the word.

Back-to-back store-conditionals and replaced reservations show whether the reservation is cleared at all; a design that forgot to clear it would write memory twice. Long stretches of mixed random traffic over a handful of words are compared cycle by cycle against a behavioural model.

// File: rtl/rsv_pkg.sv
// Shared types for the reservation monitor.
// Assumes: one reservation, one update decision per cycle.
package rsv_pkg;

    // Action applied to the reservation register at the next edge.
    typedef enum logic [1:0] {
        RSV_KEEP = 2'd0,
        RSV_LOAD = 2'd1,
        RSV_DROP = 2'd2
    } rsv_op_e;

endpackage

// File: rtl/rsv_word_cmp.sv
// Compares a stored word address against a full byte address.
// Assumes: OFS_W low address bits select a byte inside a word and are ignored.
module rsv_word_cmp #(
    parameter int ADDR_W = 32,
    parameter int OFS_W  = 2,
    localparam int WORD_W = ADDR_W - OFS_W
) (
    input  logic [WORD_W-1:0] word_a,
    input  logic [ADDR_W-1:0] addr_b,
    output logic              hit
);
    generate
        if (OFS_W == 0) begin : g_full
            // Purpose: no byte offset, compare every bit.
            always_comb hit = (word_a == addr_b);
        end else begin : g_drop
            // Purpose: compare only the word part of the byte address.
            always_comb hit = (word_a == addr_b[ADDR_W-1:OFS_W]);
        end
    endgenerate
endmodule

// File: rtl/rsv_state.sv
// Holds the single reservation (valid flag and word address).
// Assumes: the caller resolves same-cycle priority into one op.
module rsv_state
    import rsv_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int OFS_W  = 2,
    localparam int WORD_W = ADDR_W - OFS_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  rsv_op_e           op,
    input  logic [ADDR_W-1:0] load_addr,
    output logic              rsv_vld,
    output logic [WORD_W-1:0] rsv_word
);
    // Purpose: apply the chosen op to the reservation register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsv_vld  <= 1'b0;
            rsv_word <= '0;
        end else begin
            case (op)
                RSV_LOAD: begin
                    rsv_vld  <= 1'b1;
                    rsv_word <= load_addr[ADDR_W-1:OFS_W];
                end
                RSV_DROP: rsv_vld <= 1'b0;
                default:  ;
            endcase
        end
    end

    AST_LOAD_SETS: assert property (@(posedge clk) disable iff (!rst_n)
        (op == RSV_LOAD) |=> rsv_vld); // R1
    AST_DROP_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (op == RSV_DROP) |=> !rsv_vld); // R6
endmodule

// File: rtl/rsv_sc_judge.sv
// Registers the store-conditional outcome: memory store and register result.
// Assumes: pass is already qualified with the request, reservation and conflicts.
module rsv_sc_judge #(
    parameter int ADDR_W = 32,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sc_req,
    input  logic              pass,
    input  logic              rsv_vld,
    input  logic [ADDR_W-1:0] sc_addr,
    input  logic [DATA_W-1:0] sc_data,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_waddr,
    output logic [DATA_W-1:0] mem_wdata,
    output logic              sc_done,
    output logic [DATA_W-1:0] sc_status
);
    // Purpose: launch the store and return 1/0 one cycle after the request.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mem_we    <= 1'b0;
            mem_waddr <= '0;
            mem_wdata <= '0;
            sc_done   <= 1'b0;
            sc_status <= '0;
        end else begin
            mem_we    <= sc_req & pass;
            mem_waddr <= sc_addr;
            mem_wdata <= sc_data;
            sc_done   <= sc_req;
            sc_status <= DATA_W'(sc_req & pass);
        end
    end

    AST_WE_NEEDS_RSV: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |-> $past(rsv_vld)); // R3
    AST_WE_NEEDS_SC: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |-> $past(sc_req)); // R11
    AST_DONE_AFTER_SC: assert property (@(posedge clk) disable iff (!rst_n)
        sc_req |=> sc_done); // R11
endmodule

// File: rtl/excl_reserve_unit.sv
// Load-linked / store-conditional reservation monitor for one processor.
// Assumes: at most one LL and one SC per cycle; write notices come from other agents.
// Same-cycle order: flush > LL > SC > external write.
module excl_reserve_unit
    import rsv_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int DATA_W = 32,
    parameter int OFS_W  = 2,
    localparam int WORD_W = ADDR_W - OFS_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ll_req,
    input  logic [ADDR_W-1:0] ll_addr,
    input  logic              sc_req,
    input  logic [ADDR_W-1:0] sc_addr,
    input  logic [DATA_W-1:0] sc_data,
    input  logic              ext_wr,
    input  logic [ADDR_W-1:0] ext_addr,
    input  logic              flush,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_waddr,
    output logic [DATA_W-1:0] mem_wdata,
    output logic              sc_done,
    output logic [DATA_W-1:0] sc_status
);
    logic              rsv_vld;
    logic [WORD_W-1:0] rsv_word;
    logic              sc_hit;
    logic              ext_hit;
    logic              sc_pass;
    rsv_op_e           nxt_op;

    rsv_word_cmp #(.ADDR_W(ADDR_W), .OFS_W(OFS_W)) u_sc_cmp (
        .word_a(rsv_word), .addr_b(sc_addr), .hit(sc_hit));

    rsv_word_cmp #(.ADDR_W(ADDR_W), .OFS_W(OFS_W)) u_ext_cmp (
        .word_a(rsv_word), .addr_b(ext_addr), .hit(ext_hit));

    // Purpose: SC succeeds only on a live, matching, unbroken reservation.
    always_comb sc_pass = rsv_vld & sc_hit & ~flush & ~(ext_wr & ext_hit);

    // Purpose: resolve same-cycle events into one reservation update.
    always_comb begin
        if (flush)                  nxt_op = RSV_DROP;
        else if (ll_req)            nxt_op = RSV_LOAD;
        else if (sc_req)            nxt_op = RSV_DROP;
        else if (ext_wr && ext_hit) nxt_op = RSV_DROP;
        else                        nxt_op = RSV_KEEP;
    end

    rsv_state #(.ADDR_W(ADDR_W), .OFS_W(OFS_W)) u_state (
        .clk(clk), .rst_n(rst_n), .op(nxt_op), .load_addr(ll_addr),
        .rsv_vld(rsv_vld), .rsv_word(rsv_word));

    rsv_sc_judge #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_judge (
        .clk(clk), .rst_n(rst_n), .sc_req(sc_req), .pass(sc_pass),
        .rsv_vld(rsv_vld), .sc_addr(sc_addr), .sc_data(sc_data),
        .mem_we(mem_we), .mem_waddr(mem_waddr), .mem_wdata(mem_wdata),
        .sc_done(sc_done), .sc_status(sc_status));

    AST_FLUSH_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> !rsv_vld); // R8
    AST_WE_ONLY_WITH_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |-> sc_done); // R11
    AST_NO_WE_AFTER_FLUSH: assert property (@(posedge clk) disable iff (!rst_n)
        $past(flush) |-> !mem_we); // R8
endmodule

// File: tb/excl_reserve_unit_bench.sv
`timescale 1ns/1ps
module excl_reserve_unit_bench;
    localparam int AW = 32;
    localparam int DW = 32;
    localparam int OW = 2;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          ll_req = 0, sc_req = 0, ext_wr = 0, flush = 0;
    logic [AW-1:0] ll_addr = '0, sc_addr = '0, ext_addr = '0;
    logic [DW-1:0] sc_data = '0;
    logic          mem_we, sc_done;
    logic [AW-1:0] mem_waddr;
    logic [DW-1:0] mem_wdata, sc_status;

    int n_tests = 0;
    int n_fail  = 0;
    bit chk_en  = 0;
    bit done    = 0;
    string cur_tag = "R10";
    string e_tag   = "R10";

    // behavioural reference state and expected outputs
    bit          m_vld = 0;
    logic [AW-1:0] m_word = '0;
    bit          e_we = 0, e_done = 0;
    logic [AW-1:0] e_waddr = '0;
    logic [DW-1:0] e_wdata = '0, e_status = '0;

    always #2 clk = ~clk;   // 250 MHz

    excl_reserve_unit #(.ADDR_W(AW), .DATA_W(DW), .OFS_W(OW)) u_excl_reserve_unit (
        .clk(clk), .rst_n(rst_n), .ll_req(ll_req), .ll_addr(ll_addr),
        .sc_req(sc_req), .sc_addr(sc_addr), .sc_data(sc_data),
        .ext_wr(ext_wr), .ext_addr(ext_addr), .flush(flush),
        .mem_we(mem_we), .mem_waddr(mem_waddr), .mem_wdata(mem_wdata),
        .sc_done(sc_done), .sc_status(sc_status));

    // reference model: computes what the outputs must be after this edge
    always @(posedge clk) begin
        bit pass;
        e_tag = cur_tag;
        chk_en = 1;
        if (!rst_n) begin
            m_vld = 0; e_we = 0; e_done = 0;
            e_waddr = '0; e_wdata = '0; e_status = '0;
        end else begin
            pass = sc_req && m_vld && ((sc_addr >> OW) == m_word) && !flush
                   && !(ext_wr && ((ext_addr >> OW) == m_word));
            e_we = pass; e_done = sc_req;
            e_waddr = sc_addr; e_wdata = sc_data;
            e_status = pass ? DW'(1) : DW'(0);
            if (flush) m_vld = 0;
            else if (ll_req) begin m_vld = 1; m_word = ll_addr >> OW; end
            else if (sc_req) m_vld = 0;
            else if (ext_wr && ((ext_addr >> OW) == m_word)) m_vld = 0;
        end
    end

    // comparison away from the active edge
    always @(negedge clk) begin
        if (chk_en && !done) begin
            n_tests++;
            if (mem_we !== e_we || sc_done !== e_done || sc_status !== e_status ||
                (e_we && (mem_waddr !== e_waddr || mem_wdata !== e_wdata)) ||
                (!rst_n && (mem_waddr !== '0 || mem_wdata !== '0))) begin
                n_fail++;
                $display("FAIL %s: we=%0b done=%0b status=%0h addr=%h data=%h expected we=%0b done=%0b status=%0h addr=%h data=%h",
                         e_tag, mem_we, sc_done, sc_status, mem_waddr, mem_wdata,
                         e_we, e_done, e_status, e_waddr, e_wdata);
            end
        end
    end

    task automatic cyc(input bit l, input logic [AW-1:0] la,
                       input bit s, input logic [AW-1:0] sa, input logic [DW-1:0] sd,
                       input bit x, input logic [AW-1:0] xa, input bit f, input string tag);
        @(negedge clk);
        ll_req = l; ll_addr = la; sc_req = s; sc_addr = sa; sc_data = sd;
        ext_wr = x; ext_addr = xa; flush = f; cur_tag = tag;
    endtask

    task automatic idle(input string tag);
        cyc(0, '0, 0, '0, '0, 0, '0, 0, tag);
    endtask

    initial begin
        #400_000;
        if (!done) begin
            n_tests++; n_fail++;
            $display("FAIL watchdog: run did not complete, expected completion");
            done = 1;
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        cur_tag = "R10";
        repeat (3) @(negedge clk);
        rst_n = 1;
        idle("R10");
        // R1 / R2: basic success
        cyc(1, 32'h100, 0, '0, '0, 0, '0, 0, "R1");
        cyc(0, '0, 1, 32'h100, 32'hCAFE0001, 0, '0, 0, "R2");
        idle("R2");
        // R6: second SC without new LL fails
        cyc(0, '0, 1, 32'h100, 32'h1, 0, '0, 0, "R6");
        idle("R6");
        // R3: no reservation
        cyc(0, '0, 1, 32'h200, 32'h2, 0, '0, 0, "R3");
        // R4: other byte of the word succeeds, other word fails
        cyc(1, 32'h200, 0, '0, '0, 0, '0, 0, "R4");
        cyc(0, '0, 1, 32'h203, 32'h3, 0, '0, 0, "R4");
        cyc(1, 32'h200, 0, '0, '0, 0, '0, 0, "R4");
        cyc(0, '0, 1, 32'h204, 32'h4, 0, '0, 0, "R4");
        // R5: write notice to other word keeps, to any byte of word clears
        cyc(1, 32'h300, 0, '0, '0, 0, '0, 0, "R5");
        cyc(0, '0, 0, '0, '0, 1, 32'h304, 0, "R5");
        cyc(0, '0, 1, 32'h302, 32'h5, 0, '0, 0, "R5");
        cyc(1, 32'h300, 0, '0, '0, 0, '0, 0, "R5");
        cyc(0, '0, 0, '0, '0, 1, 32'h301, 0, "R5");
        cyc(0, '0, 1, 32'h300, 32'h6, 0, '0, 0, "R5");
        // R7: newer LL replaces older
        cyc(1, 32'h400, 0, '0, '0, 0, '0, 0, "R7");
        cyc(1, 32'h500, 0, '0, '0, 0, '0, 0, "R7");
        cyc(0, '0, 1, 32'h400, 32'h7, 0, '0, 0, "R7");
        // R8: flush clears, flush beats SC, flush beats LL
        cyc(1, 32'h600, 0, '0, '0, 0, '0, 0, "R8");
        cyc(0, '0, 0, '0, '0, 0, '0, 1, "R8");
        cyc(0, '0, 1, 32'h600, 32'h8, 0, '0, 0, "R8");
        cyc(1, 32'h600, 0, '0, '0, 0, '0, 0, "R8");
        cyc(0, '0, 1, 32'h600, 32'h9, 0, '0, 1, "R8");
        cyc(1, 32'h600, 0, '0, '0, 0, '0, 1, "R8");
        cyc(0, '0, 1, 32'h600, 32'hA, 0, '0, 0, "R8");
        // R9: same-cycle orderings
        cyc(1, 32'h700, 0, '0, '0, 0, '0, 0, "R9");
        cyc(0, '0, 1, 32'h700, 32'hB, 1, 32'h702, 0, "R9");
        cyc(1, 32'h700, 0, '0, '0, 0, '0, 0, "R9");
        cyc(1, 32'h800, 1, 32'h700, 32'hC, 0, '0, 0, "R9");
        cyc(0, '0, 1, 32'h800, 32'hD, 0, '0, 0, "R9");
        cyc(1, 32'h900, 0, '0, '0, 1, 32'h900, 0, "R9");
        cyc(0, '0, 1, 32'h900, 32'hE, 0, '0, 0, "R9");
        idle("R11");
        // R11 and all rules: random traffic over a few words
        for (int i = 0; i < 3000; i++) begin
            logic [AW-1:0] a1, a2, a3;
            a1 = {28'h0, 2'($urandom_range(0, 3)), 2'($urandom)};
            a2 = {28'h0, 2'($urandom_range(0, 3)), 2'($urandom)};
            a3 = {28'h0, 2'($urandom_range(0, 3)), 2'($urandom)};
            cyc(($urandom % 3) == 0, a1, ($urandom % 3) == 0, a2, DW'($urandom),
                ($urandom % 5) == 0, a3, ($urandom % 17) == 0, "R11");
        end
        idle("R11");
        // R10: reset in the middle clears outputs and reservation
        cyc(1, 32'hA00, 0, '0, '0, 0, '0, 0, "R10");
        @(negedge clk); rst_n = 0; cur_tag = "R10";
        idle("R10");
        @(negedge clk); rst_n = 1;
        cyc(0, '0, 1, 32'hA00, 32'hF, 0, '0, 0, "R10");
        idle("R10");
        idle("R10");
        @(negedge clk);
        done = 1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule